// File: doc/BRIEF.md
# Flash byte-programming controller

This block is the parallel programming front end of an on-chip code flash. The array itself is a synthesizable register memory that powers up erased. A 4-bit mode code and an active-low program strobe select what the block does. It can write a byte, set one of three lock bits, erase the whole chip, read a byte back for verify, or return identification bytes. The array depth comes from the address-width parameter, which defaults to 4 KB.

A write starts on the rising edge of the strobe and then times itself. The write duration and the minimum strobe low time for an erase are counted in system clock cycles. Both are parameters, so a simulation can use short values. While a write is running, software can watch the ready output. It can also poll the last written address, which returns bit 7 inverted until the cycle ends. Lock bits 1 and 2 block code verify. No mode reads any lock bit back.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, ready is 1 and rdata is 0xFF. No lock bit is set, and every array byte reads 0xFF.
- R2: Mode code 0x1 writes a byte. A strobe rise sampled while ready is 1 stores (old byte AND wdata) at addr, so a write never turns a 0 bit into 1. Once the write completes, a read returns the stored value.
- R3: Ready falls at the clock edge that first samples the strobe high after low. For byte writes and lock writes it stays low for exactly WRITE_CYC cycles.
- R4: During a byte write, a read (mode 0x2) of the address being written returns the written data with bit 7 inverted. A read of any other address returns 0xFF.
- R5: Mode code 0x6 is chip erase. An erase starts only if the strobe was sampled low in that mode on at least ERASE_CYC consecutive edges before its rise. A shorter pulse has no effect and ready stays 1.
- R6: Once accepted, an erase clears all lock bits at once and holds ready low for 2^ADDR_W + 1 cycles. Reads return 0xFF while it runs, and every byte reads 0xFF afterwards.
- R7: Mode code 0x7 reads identification bytes. Address 0x030 returns 0x1E and 0x031 returns 0x61. Address 0x032 returns 0xFF when HV_MODE=1 and 0x05 when HV_MODE=0. Every other address returns 0xFF. The lock bits do not affect this mode.
- R8: Mode codes 0x3, 0x4 and 0x5 set lock bit 1, 2 and 3. While lock bit 1 or lock bit 2 is set, a byte read returns 0xFF. Lock bit 3 on its own does not block reads.
- R9: A write, lock or erase strobe whose rise is sampled while ready is 0 is ignored.
- R10: rdata answers the mode and addr sampled at one edge on the following edge. Any mode other than 0x2 and 0x7 gives 0xFF. Codes other than 0x1 to 0x7 start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 4 | Operation code from the four control pins |
| prog_n | input | 1 | Program strobe, active low; the rising edge starts a write |
| addr | input | ADDR_W | Byte address, or identification index |
| wdata | input | 8 | Byte to program |
| rdata | output | 8 | Registered read result |
| ready | output | 1 | High when idle, low while a write or erase runs |

## Verification
Read results appear one clock edge after the edge that samples mode and address, so each explicit read waits two rising edges after driving the inputs. Ready falls at the same edge that samples the strobe high. It stays low for WRITE_CYC cycles after a byte or lock write and for 2^ADDR_W + 1 cycles after an erase. Busy lengths are measured by counting falling edges until ready returns. The bench drives inputs on the falling edge and steps a behavioural reference model on each rising edge. It compares rdata and ready against that model on every falling edge, so each result is checked in the cycle it is due.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ERASED = 8'hFF;

  localparam logic [3:0] MD_WR_BYTE = 4'h1;
  localparam logic [3:0] MD_RD_BYTE = 4'h2;
  localparam logic [3:0] MD_LOCK1   = 4'h3;
  localparam logic [3:0] MD_LOCK2   = 4'h4;
  localparam logic [3:0] MD_LOCK3   = 4'h5;
  localparam logic [3:0] MD_ERASE   = 4'h6;
  localparam logic [3:0] MD_RD_SIG  = 4'h7;

  localparam logic [BYTE_W-1:0] ID_VENDOR = 8'h1E;
  localparam logic [BYTE_W-1:0] ID_DEVICE = 8'h61;
  localparam logic [BYTE_W-1:0] ID_HIGHV  = 8'hFF;
  localparam logic [BYTE_W-1:0] ID_LOWV   = 8'h05;

  typedef enum logic [1:0] {
    OP_BYTE  = 2'd0,
    OP_LOCK  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;
endpackage

// File: rtl/flash_strobe_dec.sv
module flash_strobe_dec
  import flash_prog_pkg::*;
#(
  parameter int ERASE_CYC = 1250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode_sel,
  input  logic       prog_n,
  output logic       cmd_go,
  output op_e        cmd_op,
  output logic [1:0] cmd_lock_idx
);
  localparam int LOW_W = $clog2(ERASE_CYC + 1);
  localparam logic [LOW_W-1:0] LOW_MAX = LOW_W'(ERASE_CYC);

  logic             prog_q;
  logic [LOW_W-1:0] low_cnt;
  logic             rise;

  // strobe history and saturating low-time counter for erase
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      prog_q <= prog_n;
      if (!prog_n && mode_sel == MD_ERASE) begin
        if (low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
    end
  end

  always_comb begin
    rise         = prog_n & ~prog_q;
    cmd_go       = 1'b0;
    cmd_op       = OP_BYTE;
    cmd_lock_idx = 2'd0;
    case (mode_sel)
      MD_WR_BYTE: cmd_go = rise;
      MD_LOCK1: begin
        cmd_go = rise;
        cmd_op = OP_LOCK;
        cmd_lock_idx = 2'd0;
      end
      MD_LOCK2: begin
        cmd_go = rise;
        cmd_op = OP_LOCK;
        cmd_lock_idx = 2'd1;
      end
      MD_LOCK3: begin
        cmd_go = rise;
        cmd_op = OP_LOCK;
        cmd_lock_idx = 2'd2;
      end
      MD_ERASE: begin
        cmd_go = rise && (low_cnt == LOW_MAX);
        cmd_op = OP_ERASE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 187500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  op_e               cmd_op,
  input  logic [1:0]        cmd_lock_idx,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] ram_q,
  output logic              ready,
  output op_e               op,
  output logic [ADDR_W-1:0] la,
  output logic [BYTE_W-1:0] ld,
  output logic [2:0]        locks,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_wa,
  output logic [BYTE_W-1:0] ram_wd
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CNT_TOP = (WRITE_CYC > DEPTH + 1) ? WRITE_CYC : DEPTH + 1;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WRITE_CYC - 1);
  localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt;
  logic             byte_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b1;
      op    <= OP_BYTE;
      cnt   <= '0;
      la    <= '0;
      ld    <= ERASED;
      locks <= '0;
    end else if (!ready) begin
      if (cnt == '0) ready <= 1'b1;
      else cnt <= cnt - 1'b1;
    end else if (cmd_go) begin
      ready <= 1'b0;
      op    <= cmd_op;
      la    <= addr;
      ld    <= wdata;
      if (cmd_op == OP_ERASE) begin
        cnt   <= ER_LOAD;
        locks <= '0;
      end else begin
        cnt <= WR_LOAD;
        if (cmd_op == OP_LOCK) locks <= locks | (3'b001 << cmd_lock_idx);
      end
    end
  end

  // byte write: read-modify-write on the first busy edge; erase: sweep down
  always_comb begin
    byte_first = !ready && (op == OP_BYTE) && (cnt == WR_LOAD);
    ram_we     = byte_first || (!ready && (op == OP_ERASE) && (cnt != '0));
    ram_wa     = (op == OP_ERASE) ? ADDR_W'(cnt - 1'b1) : la;
    ram_wd     = (op == OP_ERASE) ? ERASED : (ram_q & ld);
  end
endmodule

// File: rtl/flash_array_ram.sv
module flash_array_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    q <= mem[ra];
  end
endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter bit HV_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        mode_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] ram_q,
  input  logic              ready,
  input  op_e               op,
  input  logic [ADDR_W-1:0] la,
  input  logic [BYTE_W-1:0] ld,
  input  logic [2:0]        locks,
  output logic [BYTE_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] ID0_A = ADDR_W'(12'h030);
  localparam logic [ADDR_W-1:0] ID1_A = ADDR_W'(12'h031);
  localparam logic [ADDR_W-1:0] ID2_A = ADDR_W'(12'h032);
  localparam logic [BYTE_W-1:0] ID2_V = HV_MODE ? ID_HIGHV : ID_LOWV;

  logic [3:0]        s1_mode;
  logic [ADDR_W-1:0] s1_addr;
  logic [BYTE_W-1:0] id_byte;
  logic [BYTE_W-1:0] nxt;

  always_comb begin
    if (s1_addr == ID0_A)      id_byte = ID_VENDOR;
    else if (s1_addr == ID1_A) id_byte = ID_DEVICE;
    else if (s1_addr == ID2_A) id_byte = ID2_V;
    else                       id_byte = ERASED;

    nxt = ERASED;
    case (s1_mode)
      MD_RD_SIG: nxt = id_byte;
      MD_RD_BYTE: begin
        if (locks[0] | locks[1]) nxt = ERASED;
        else if (!ready)
          nxt = (op == OP_BYTE && s1_addr == la) ? {~ld[BYTE_W-1], ld[BYTE_W-2:0]} : ERASED;
        else nxt = ram_q;
      end
      default: nxt = ERASED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_mode <= '0;
      s1_addr <= '0;
      rdata   <= ERASED;
    end else begin
      s1_mode <= mode_sel;
      s1_addr <= addr;
      rdata   <= nxt;
    end
  end
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WRITE_CYC = 187500,
  parameter int ERASE_CYC = 1250000,
  parameter bit HV_MODE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        mode_sel,
  input  logic              prog_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ready
);
  logic              cmd_go;
  op_e               cmd_op;
  logic [1:0]        cmd_lock_idx;
  op_e               op;
  logic [ADDR_W-1:0] la;
  logic [BYTE_W-1:0] ld;
  logic [2:0]        locks;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_wa;
  logic [BYTE_W-1:0] ram_wd;
  logic [BYTE_W-1:0] ram_q;

  flash_strobe_dec #(.ERASE_CYC(ERASE_CYC)) u_dec (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .prog_n(prog_n),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_lock_idx(cmd_lock_idx)
  );

  flash_prog_seq #(.ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC)) u_seq (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_op(cmd_op),
    .cmd_lock_idx(cmd_lock_idx), .addr(addr), .wdata(wdata), .ram_q(ram_q),
    .ready(ready), .op(op), .la(la), .ld(ld), .locks(locks),
    .ram_we(ram_we), .ram_wa(ram_wa), .ram_wd(ram_wd)
  );

  flash_array_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
    .clk(clk), .we(ram_we), .wa(ram_wa), .wd(ram_wd), .ra(addr), .q(ram_q)
  );

  flash_read_path #(.ADDR_W(ADDR_W), .HV_MODE(HV_MODE)) u_rd (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .addr(addr), .ram_q(ram_q),
    .ready(ready), .op(op), .la(la), .ld(ld), .locks(locks), .rdata(rdata)
  );
endmodule

// File: rtl/flash_prog_ctrl_sva.sv
module flash_prog_ctrl_sva
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        mode_sel,
  input logic [ADDR_W-1:0] addr,
  input logic              prog_n,
  input logic              ready,
  input logic [7:0]        rdata,
  input logic [2:0]        locks,
  input op_e               op
);
  AST_BUSY_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> ($past(prog_n) && !$past(prog_n, 2))); // R3

  AST_LOCKS_CLEAR_ONLY_BY_ERASE: assert property (@(posedge clk) disable iff (rst)
    (|($past(locks) & ~locks)) |-> (op == OP_ERASE && !ready)); // R6

  AST_NON_READ_GIVES_ERASED: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != MD_RD_BYTE && mode_sel != MD_RD_SIG) |=> ##1 (rdata == 8'hFF)); // R10

  AST_LOCKED_VERIFY_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == MD_RD_BYTE && (locks[0] || locks[1])) |=> ##1 (rdata == 8'hFF)); // R8

  AST_VENDOR_ID: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == MD_RD_SIG && addr == ADDR_W'(12'h030)) |=> ##1 (rdata == 8'h1E)); // R7
endmodule

bind flash_prog_ctrl flash_prog_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .addr(addr), .prog_n(prog_n),
  .ready(ready), .rdata(rdata), .locks(locks), .op(op)
);

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
  import flash_prog_pkg::*;

  localparam int AW    = 12;
  localparam int WC    = 8;
  localparam int EC    = 20;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    mode_sel = 4'h0;
  logic          prog_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          ready;

  always #4 clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC), .HV_MODE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .prog_n(prog_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready)
  );

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int       m_mem [DEPTH];
  bit       m_ready = 1'b1;
  int       m_left = 0;
  int       m_op = 0;
  int       m_la = 0;
  int       m_ld = 255;
  bit [2:0] m_lock = '0;
  bit       m_prev = 1'b1;
  int       m_low = 0;
  int       m_q = 255;
  int       s1_mode = 0;
  int       s1_addr = 0;
  int       m_rdata = 255;

  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;

  function automatic int id_of(input int a);
    if (a == 'h30) return 'h1E;
    if (a == 'h31) return 'h61;
    if (a == 'h32) return 'h05;
    return 255;
  endfunction

  always @(posedge clk) begin : p_model
    int nr;
    bit rise;
    bit go;
    int opn;
    if (rst) begin
      m_ready = 1'b1; m_left = 0; m_op = 0; m_la = 0; m_ld = 255; m_lock = '0;
      m_prev = 1'b1; m_low = 0; s1_mode = 0; s1_addr = 0; m_rdata = 255;
      m_q = m_mem[addr];
    end else begin
      nr = 255;
      if (s1_mode == 7) nr = id_of(s1_addr);
      else if (s1_mode == 2) begin
        if (m_lock[0] || m_lock[1]) nr = 255;
        else if (!m_ready) nr = (m_op == 0 && s1_addr == m_la) ? (m_ld ^ 128) : 255;
        else nr = m_q;
      end
      m_rdata = nr;
      m_q = m_mem[addr];
      rise = prog_n && !m_prev;
      if (!m_ready) begin
        if (m_left == 0) m_ready = 1'b1;
        else m_left--;
      end else if (rise) begin
        go = 1'b1;
        opn = 0;
        case (mode_sel)
          4'h1: opn = 0;
          4'h3, 4'h4, 4'h5: opn = 1;
          4'h6: begin opn = 2; go = (m_low >= EC); end
          default: go = 1'b0;
        endcase
        if (go) begin
          m_ready = 1'b0; m_op = opn; m_la = addr; m_ld = wdata;
          if (opn == 0) begin
            m_mem[addr] = m_mem[addr] & wdata;
            m_left = WC - 1;
          end else if (opn == 1) begin
            m_lock[mode_sel - 3] = 1'b1;
            m_left = WC - 1;
          end else begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 255;
            m_lock = '0;
            m_left = DEPTH;
          end
        end
      end
      if (!prog_n && mode_sel == 4'h6) m_low = (m_low < EC) ? m_low + 1 : EC;
      else m_low = 0;
      m_prev = prog_n;
      s1_mode = mode_sel;
      s1_addr = addr;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(cur_req, "rdata vs model", rdata, m_rdata);
      chk(cur_req, "ready vs model", ready, m_ready);
    end
  end

  task automatic pulse(input logic [3:0] m, input int a, input int d, input int low);
    @(negedge clk);
    mode_sel = m; addr = AW'(a); wdata = 8'(d); prog_n = 1'b0;
    repeat (low) @(negedge clk);
    prog_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic rd(input logic [3:0] m, input int a, input int exp, input string req);
    @(negedge clk);
    mode_sel = m; addr = AW'(a);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(req, "read", rdata, exp);
  endtask

  task automatic busy_len(input int exp, input string req);
    int n = 0;
    @(negedge clk);
    while (!ready) begin n++; @(negedge clk); end
    chk(req, "busy length", n, exp);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
    chk("R1", "ready after reset", ready, 1);
    chk("R1", "rdata after reset", rdata, 8'hFF);
    rd(MD_RD_BYTE, 'h000, 'hFF, "R1");
    rd(MD_RD_BYTE, 'hFFF, 'hFF, "R1");

    cur_req = "R4";
    pulse(MD_WR_BYTE, 'h005, 'hA5, 1);
    rd(MD_RD_BYTE, 'h005, 'h25, "R4");
    rd(MD_RD_BYTE, 'h006, 'hFF, "R4");
    wait_ready();
    cur_req = "R2";
    rd(MD_RD_BYTE, 'h005, 'hA5, "R2");

    cur_req = "R3";
    pulse(MD_WR_BYTE, 'h005, 'h5A, 2);
    busy_len(WC, "R3");
    rd(MD_RD_BYTE, 'h005, 'h00, "R2");

    cur_req = "R4";
    pulse(MD_WR_BYTE, 'h007, 'h3C, 1);
    rd(MD_RD_BYTE, 'h007, 'hBC, "R4");
    wait_ready();
    rd(MD_RD_BYTE, 'h007, 'h3C, "R2");

    cur_req = "R9";
    pulse(MD_WR_BYTE, 'h009, 'h00, 1);
    pulse(MD_WR_BYTE, 'h00A, 'h00, 1);
    wait_ready();
    rd(MD_RD_BYTE, 'h009, 'h00, "R9");
    rd(MD_RD_BYTE, 'h00A, 'hFF, "R9");

    cur_req = "R10";
    pulse(4'hC, 'h00B, 'h00, 1);
    @(negedge clk);
    chk("R10", "ready after undefined code", ready, 1);
    rd(MD_RD_BYTE, 'h00B, 'hFF, "R10");
    rd(MD_WR_BYTE, 'h005, 'hFF, "R10");

    cur_req = "R7";
    rd(MD_RD_SIG, 'h030, 'h1E, "R7");
    rd(MD_RD_SIG, 'h031, 'h61, "R7");
    rd(MD_RD_SIG, 'h032, 'h05, "R7");
    rd(MD_RD_SIG, 'h033, 'hFF, "R7");

    cur_req = "R8";
    pulse(MD_LOCK3, 'h000, 'h00, 1);
    busy_len(WC, "R3");
    rd(MD_RD_BYTE, 'h007, 'h3C, "R8");
    pulse(MD_LOCK1, 'h000, 'h00, 1);
    wait_ready();
    rd(MD_RD_BYTE, 'h007, 'hFF, "R8");
    rd(MD_RD_SIG, 'h031, 'h61, "R8");

    cur_req = "R5";
    pulse(MD_ERASE, 'h000, 'h00, EC - 1);
    @(negedge clk);
    chk("R5", "ready after short erase strobe", ready, 1);
    rd(MD_RD_BYTE, 'h007, 'hFF, "R5");

    cur_req = "R6";
    pulse(MD_ERASE, 'h000, 'h00, EC);
    rd(MD_RD_BYTE, 'h009, 'hFF, "R6");
    busy_len(DEPTH + 1 - 3, "R6");
    rd(MD_RD_BYTE, 'h007, 'hFF, "R6");
    rd(MD_RD_BYTE, 'h009, 'hFF, "R6");
    pulse(MD_WR_BYTE, 'h009, 'h12, 1);
    wait_ready();
    rd(MD_RD_BYTE, 'h009, 'h12, "R6");

    done = 1'b1;
    cmp_en = 1'b0;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule